// File: doc/BRIEF.md
# Ancillary Data Packet Inserter

The block places one ancillary data packet into the luma half of a 20-bit video word stream. A video timing source outside the block marks the positions where a packet may go (`slot_open`) and gives the current line and field. The block raises `pkt_ready` at such a position, except on the two lines that follow the switching line of the current field. The switching line is set per field through two 13-bit inputs.

The user answers with a staggered handshake. It raises `pkt_en` two clock cycles after it sees `pkt_ready`. It then presents its bytes on `pkt_data` one per clock, starting two cycles after `pkt_en` is first sampled high. The order of the bytes is data ID, secondary data ID, data count, and then the user words. The block emits the flag preamble itself. It extends each user byte to a 10-bit word with a parity bit and an inverted parity bit, and it appends a checksum word. The chroma half is never touched. Every output word is registered, so video passes through with one cycle of latency.

Top module: `anc_pkt_inserter`

## Requirements
- R1: `pkt_ready` is high exactly when `slot_open` is high, no packet is in progress and the current line is not suppressed (R8). After reset, `vid_out` is zero and no packet is in progress.
- R2: A packet starts on a clock edge where `pkt_ready` is high and `pkt_en` is high after being low at the previous edge. `vid_out` luma carries 0x000, then 0x3FF, then 0x3FF, starting with the output of that edge.
- R3: `pkt_data` is sampled on the 2nd edge after the start edge and on each edge after that. The bytes in order are the data ID, the secondary data ID and the data count. Each one appears on luma one cycle after it is sampled, directly after the preamble.
- R4: Every data word is {~p, p, byte}: bit 8 (p) is the XOR of byte bits 7:0, which gives even parity over bits 8:0, and bit 9 is the inverse of bit 8. The user words follow the data count on luma in the order received.
- R5: After the last data word, luma carries the checksum word. Bits 8:0 are the 9-bit sum, modulo 512, of bits 8:0 of every word from the data ID through the last user word. Bit 9 is the inverse of bit 8.
- R6: The number of user words equals the data count value, from 0 to 255. A packet occupies 7 + count output cycles, and `pkt_ready` can return on the cycle after the checksum.
- R7: Outside a packet, `vid_out` equals `vid_in` delayed by one cycle. Chroma (bits 9:0) always equals `vid_in[9:0]` delayed by one cycle. Luma is bits 19:10.
- R8: With `field_id` 0 the switching line is `sw_line_f1`, and with `field_id` 1 it is `sw_line_f2`. `pkt_ready` is low on lines switching+1 and switching+2, and is not suppressed on other lines.
- R9: A `pkt_en` rise while `pkt_ready` is low starts no packet, and video passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_in | input | 20 | Video word, luma 19:10, chroma 9:0 |
| slot_open | input | 1 | Current position may carry a packet |
| line_num | input | 13 | Current video line |
| field_id | input | 1 | 0 = field 1, 1 = field 2 |
| sw_line_f1 | input | 13 | Switching line of field 1 |
| sw_line_f2 | input | 13 | Switching line of field 2 |
| pkt_en | input | 1 | User packet enable |
| pkt_data | input | 8 | User byte bus |
| pkt_ready | output | 1 | Packet may be offered now |
| vid_out | output | 20 | Video word with packet on luma |

## Verification
The assertions check the following on every cycle:
- chroma is delayed by exactly one cycle;
- each data word carries correct parity and inverse bits;
- the checksum word has its bit 9 inverted against bit 8;
- the start of a packet always leads to the preamble state;
- the word index never passes the 255-word limit.

Only the bench scenarios can show the rest:
- the exact two-cycle sampling offsets;
- the byte order and checksum value;
- the packet lengths for data counts of 0, 3 and 255;
- the per-field choice of suppressed lines;
- that enable pulses on suppressed lines or closed slots leave the video untouched.

// File: rtl/anc_pkg.sv
// Shared constants and word helpers for the ancillary packet inserter.
// Assumes 8-bit user bytes carried as 10-bit words.
package anc_pkg;
    localparam int ANC_DW = 8;
    localparam int ANC_WW = ANC_DW + 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FLAG = 2'd1,
        ST_BODY = 2'd2,
        ST_SUM  = 2'd3
    } anc_st_t;

    // Extend a byte to a word: bit 8 even parity, bit 9 its inverse.
    function automatic logic [ANC_WW-1:0] anc_word(input logic [ANC_DW-1:0] b);
        logic p;
        p = ^b;
        return {~p, p, b};
    endfunction
endpackage

// File: rtl/anc_line_gate.sv
// Line gate: flags whether the current line may carry a packet.
// Suppresses the GUARD lines after the switching line of the active field.
// Assumes line numbers wrap modulo 2**LW.
module anc_line_gate #(
    parameter int LW    = 13,
    parameter int GUARD = 2
) (
    input  logic [LW-1:0] line_num,
    input  logic          field_id,
    input  logic [LW-1:0] sw_f1,
    input  logic [LW-1:0] sw_f2,
    output logic          pass_o
);
    logic [LW-1:0]    sw_sel;
    logic [GUARD-1:0] hit;

    // Pick the switching line of the current field.
    assign sw_sel = field_id ? sw_f2 : sw_f1;

    for (genvar g = 0; g < GUARD; g++) begin : g_guard
        // One comparator per suppressed line after the switching point.
        assign hit[g] = (line_num == sw_sel + LW'(g + 1));
    end

    assign pass_o = ~|hit;
endmodule

// File: rtl/anc_pkt_fsm.sv
// Packet sequencer: handshake, preamble, parity words, count and checksum.
// Produces the luma word for the coming edge combinationally; the caller
// registers it. Assumes the user honours the two-cycle data offset.
module anc_pkt_fsm
    import anc_pkg::*;
#(
    parameter int DW = ANC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_ok,
    input  logic          pkt_en,
    input  logic [DW-1:0] pkt_data,
    output logic          ready,
    output logic          ins_act,
    output logic [DW+1:0] ins_word,
    output logic          ins_data,
    output logic          ins_sum
);
    localparam int WW = DW + 2;
    localparam int IW = $clog2((2 ** DW) + 3);
    localparam logic [IW-1:0] IDX_MAX = IW'((2 ** DW) + 1);

    anc_st_t        st;
    logic           flag_cnt;
    logic [IW-1:0]  idx;
    logic [DW-1:0]  dc_q;
    logic [DW-1:0]  byte_q;
    logic [DW:0]    cs_q;
    logic           en_q;
    logic           start;
    logic           last;
    logic [WW-1:0]  body_word;

    // Handshake: ready while idle in an open slot; start on enable rise.
    assign ready     = slot_ok && (st == ST_IDLE);
    assign start     = ready && pkt_en && !en_q;
    assign body_word = anc_word(byte_q);
    // Final data word: count word of zero, or user word number dc.
    assign last = ((idx == IW'(2)) && (byte_q == '0)) ||
                  ((idx > IW'(2)) && (idx == IW'(2) + IW'(dc_q)));

    // Select the luma word that the next edge registers.
    always_comb begin
        ins_act  = 1'b1;
        ins_word = '0;
        ins_data = 1'b0;
        ins_sum  = 1'b0;
        case (st)
            ST_IDLE: ins_act = start;
            ST_FLAG: ins_word = '1;
            ST_BODY: begin
                ins_word = body_word;
                ins_data = 1'b1;
            end
            default: begin
                ins_word = {~cs_q[DW], cs_q};
                ins_sum  = 1'b1;
            end
        endcase
    end

    // Sequence state, byte capture, count and checksum accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            flag_cnt <= 1'b0;
            idx      <= '0;
            dc_q     <= '0;
            byte_q   <= '0;
            cs_q     <= '0;
            en_q     <= 1'b0;
        end else begin
            en_q <= pkt_en;
            case (st)
                ST_IDLE: if (start) begin
                    st       <= ST_FLAG;
                    flag_cnt <= 1'b0;
                    idx      <= '0;
                    cs_q     <= '0;
                end
                ST_FLAG: begin
                    flag_cnt <= 1'b1;
                    if (flag_cnt) begin
                        st     <= ST_BODY;
                        byte_q <= pkt_data;
                    end
                end
                ST_BODY: begin
                    cs_q   <= cs_q + body_word[DW:0];
                    idx    <= idx + IW'(1);
                    byte_q <= pkt_data;
                    if (idx == IW'(2)) dc_q <= byte_q;
                    if (last) st <= ST_SUM;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: an accepted enable rise always leads into the preamble.
    p_start_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st == ST_FLAG));

    // R6: the word index stays within DID, SDID, DC and 255 user words.
    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BODY) |-> (idx <= IDX_MAX));
endmodule

// File: rtl/anc_vid_mux.sv
// Output register: replaces luma with the packet word when told to,
// always passes chroma. One cycle of latency on every path.
module anc_vid_mux #(
    parameter int WW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2*WW-1:0] vid_in,
    input  logic          ins_act,
    input  logic [WW-1:0] ins_word,
    input  logic          ins_data,
    input  logic          ins_sum,
    output logic [2*WW-1:0] vid_out
);
    logic data_q;
    logic sum_q;

    // Register the merged word and the kind of inserted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_out <= '0;
            data_q  <= 1'b0;
            sum_q   <= 1'b0;
        end else begin
            vid_out <= {ins_act ? ins_word : vid_in[2*WW-1:WW], vid_in[WW-1:0]};
            data_q  <= ins_data;
            sum_q   <= ins_sum;
        end
    end

    // R7: chroma is the input chroma of the previous cycle.
    p_chroma_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (vid_out[WW-1:0] == $past(vid_in[WW-1:0])));

    // R4: data words carry even parity in bit 8 and its inverse in bit 9.
    p_word_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_q |-> ((vid_out[2*WW-1] != vid_out[2*WW-2]) &&
                    (vid_out[2*WW-2] == ^vid_out[2*WW-3:WW])));

    // R5: checksum word has bit 9 inverted against bit 8.
    p_sum_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q |-> (vid_out[2*WW-1] != vid_out[2*WW-2]));
endmodule

// File: rtl/anc_pkt_inserter.sv
// Ancillary packet inserter top: gates readiness by line, runs the packet
// sequence and merges it into luma. Assumes luma in the upper half word.
module anc_pkt_inserter
    import anc_pkg::*;
#(
    parameter int DW    = ANC_DW,
    parameter int LW    = 13,
    parameter int GUARD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*DW+3:0]   vid_in,
    input  logic              slot_open,
    input  logic [LW-1:0]     line_num,
    input  logic              field_id,
    input  logic [LW-1:0]     sw_line_f1,
    input  logic [LW-1:0]     sw_line_f2,
    input  logic              pkt_en,
    input  logic [DW-1:0]     pkt_data,
    output logic              pkt_ready,
    output logic [2*DW+3:0]   vid_out
);
    localparam int WW = DW + 2;

    logic          line_pass;
    logic          ins_act;
    logic [WW-1:0] ins_word;
    logic          ins_data;
    logic          ins_sum;

    anc_line_gate #(.LW(LW), .GUARD(GUARD)) u_gate (
        .line_num (line_num),
        .field_id (field_id),
        .sw_f1    (sw_line_f1),
        .sw_f2    (sw_line_f2),
        .pass_o   (line_pass)
    );

    anc_pkt_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_ok  (slot_open && line_pass),
        .pkt_en   (pkt_en),
        .pkt_data (pkt_data),
        .ready    (pkt_ready),
        .ins_act  (ins_act),
        .ins_word (ins_word),
        .ins_data (ins_data),
        .ins_sum  (ins_sum)
    );

    anc_vid_mux #(.WW(WW)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_in   (vid_in),
        .ins_act  (ins_act),
        .ins_word (ins_word),
        .ins_data (ins_data),
        .ins_sum  (ins_sum),
        .vid_out  (vid_out)
    );

    // R1: readiness never coexists with a closed slot.
    p_ready_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> slot_open);
endmodule

// File: tb/anc_pkt_inserter_test.sv
module anc_pkt_inserter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] vid_in = '0;
    logic        slot_open = 1'b0;
    logic [12:0] line_num = 13'd20;
    logic        field_id = 1'b0;
    logic [12:0] sw_line_f1 = 13'd7;
    logic [12:0] sw_line_f2 = 13'd300;
    logic        pkt_en = 1'b0;
    logic [7:0]  pkt_data = 8'hA5;
    logic        pkt_ready;
    logic [19:0] vid_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    anc_pkt_inserter uut (
        .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .slot_open(slot_open),
        .line_num(line_num), .field_id(field_id), .sw_line_f1(sw_line_f1),
        .sw_line_f2(sw_line_f2), .pkt_en(pkt_en), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .vid_out(vid_out)
    );

    always #2 clk = ~clk;

    // Fresh random video each cycle, changed away from the active edge.
    always @(negedge clk) vid_in <= 20'($urandom);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model.
    int    q_w[$];
    string q_t[$];
    byte   pkt_bytes[$];
    bit    m_en_prev = 0;
    bit    watch_pass = 0;
    int    pass_err = 0;

    function automatic bit m_blocked();
        logic [12:0] sw;
        sw = field_id ? sw_line_f2 : sw_line_f1;
        return (line_num == sw + 13'd1) || (line_num == sw + 13'd2);
    endfunction

    function automatic bit m_ready();
        return slot_open && (q_w.size() == 0) && !m_blocked();
    endfunction

    task automatic build_packet();
        int cs = 0;
        q_w.push_back(10'h000); q_t.push_back("R2");
        q_w.push_back(10'h3FF); q_t.push_back("R2");
        q_w.push_back(10'h3FF); q_t.push_back("R2");
        for (int i = 0; i < pkt_bytes.size(); i++) begin
            int b = int'(pkt_bytes[i]) & 255;
            int p = $countones(b) % 2;
            int w = ((1 - p) << 9) | (p << 8) | b;
            cs = (cs + (w & 511)) % 512;
            q_w.push_back(w);
            q_t.push_back(i < 3 ? "R3" : "R4");
        end
        q_w.push_back((((cs >> 8) ^ 1) << 9) | cs);
        q_t.push_back("R5");
    endtask

    always @(posedge clk) begin
        logic [19:0] exp;
        logic [9:0]  prev_luma;
        string tag;
        prev_luma = vid_in[19:10];
        tag = "R7";
        if (!rst_n) begin
            q_w.delete(); q_t.delete();
            m_en_prev = 0;
            exp = '0;
        end else begin
            if (m_ready() && pkt_en && !m_en_prev) build_packet();
            m_en_prev = pkt_en;
            if (q_w.size() > 0) begin
                exp = {10'(q_w.pop_front()), vid_in[9:0]};
                tag = q_t.pop_front();
            end else begin
                exp = vid_in;
            end
        end
        #1;
        check(tag, vid_out, exp);
        check(m_blocked() && slot_open ? "R8" : "R1", pkt_ready, m_ready());
        if (watch_pass && vid_out[19:10] !== prev_luma) pass_err++;
    end

    task automatic send_pkt(input byte did, input byte sdid, input int dc);
        int got = 0;
        pkt_bytes.delete();
        pkt_bytes.push_back(did);
        pkt_bytes.push_back(sdid);
        pkt_bytes.push_back(byte'(dc));
        for (int i = 0; i < dc; i++) pkt_bytes.push_back(byte'(i * 37 + dc));
        do @(negedge clk); while (!pkt_ready);
        @(negedge clk);
        @(negedge clk);
        pkt_en = 1'b1;
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            if (pkt_ready) begin
                got = k;
                break;
            end
            if (k >= 2 && (k - 2) < pkt_bytes.size()) pkt_data = pkt_bytes[k - 2];
            else pkt_data = 8'hA5;
        end
        check("R6", 32'(got), 32'(7 + dc));
        pkt_en = 1'b0;
        pkt_data = 8'hA5;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", vid_out, 20'h0);
        check("R1", pkt_ready, 1'b0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // Packets of several lengths on an open line of field 1.
        slot_open = 1'b1;
        send_pkt(8'h60, 8'h60, 3);
        repeat (3) @(negedge clk);
        send_pkt(8'h41, 8'h07, 0);
        repeat (3) @(negedge clk);
        send_pkt(8'hC3, 8'h5A, 255);
        repeat (3) @(negedge clk);

        // Suppressed lines per field.
        line_num = 13'd8;  @(negedge clk); check("R8", pkt_ready, 1'b0);
        line_num = 13'd9;  @(negedge clk); check("R8", pkt_ready, 1'b0);
        line_num = 13'd10; @(negedge clk); check("R8", pkt_ready, 1'b1);
        line_num = 13'd7;  @(negedge clk); check("R8", pkt_ready, 1'b1);
        field_id = 1'b1;
        line_num = 13'd301; @(negedge clk); check("R8", pkt_ready, 1'b0);
        line_num = 13'd302; @(negedge clk); check("R8", pkt_ready, 1'b0);
        line_num = 13'd8;   @(negedge clk); check("R8", pkt_ready, 1'b1);

        // Packet in field 2 on an open line.
        line_num = 13'd303;
        send_pkt(8'h61, 8'h02, 5);
        repeat (3) @(negedge clk);

        // Enable rises on a suppressed line and with the slot closed.
        watch_pass = 1;
        line_num = 13'd301;
        for (int r = 0; r < 3; r++) begin
            pkt_en = 1'b1; pkt_data = 8'h11; repeat (4) @(negedge clk);
            pkt_en = 1'b0; repeat (2) @(negedge clk);
        end
        line_num = 13'd303;
        slot_open = 1'b0;
        for (int r = 0; r < 3; r++) begin
            pkt_en = 1'b1; repeat (4) @(negedge clk);
            pkt_en = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        watch_pass = 0;
        check("R9", 32'(pass_err), 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule